// File: doc/BRIEF.md
# Single-Precision Compare Predicate Evaluator

This block compares two IEEE-754 single-precision values under a 5-bit predicate code. It returns one true/false answer, an invalid-operation flag and a denormal-input flag. Each predicate is built from three parts:

- a base relation: equal, less, less-or-equal, unordered, or a constant;
- the answer it gives when either operand is a NaN;
- whether a quiet NaN counts as an invalid operation.

Codes 16 to 31 reuse the relations of codes 0 to 15 with the quiet/signaling attribute flipped. A legacy-mode input limits decoding to the three low predicate bits, which leaves only the first eight predicates reachable.

The comparison itself is combinational. The answer and both flags are captured in one output register stage whenever `eval_en` is high, so results appear one clock after the operands are presented. While `eval_en` is low, the registered outputs hold their values.

Top module: `spc_eval`

## Requirements
- R1: While `rst_n` is low, `result_o`, `invalid_o` and `denorm_o` are 0.
- R2: When `eval_en` is low at a rising clock edge, all three outputs keep their previous values. When it is high, the outputs after that edge reflect the inputs sampled at the edge.
- R3: A value is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is nonzero. It is quiet when fraction bit 22 is 1 and signaling otherwise. An exponent of all ones with a zero fraction is an infinity and compares as an ordinary value.
- R4: Code 3 (unordered) is true exactly when at least one operand is a NaN. Code 7 (ordered) is true exactly when neither operand is a NaN.
- R5: For non-NaN operands, the base relations of codes 0 to 15 are:
  - 0: a==b
  - 1: a<b
  - 2: a<=b
  - 4: a!=b
  - 5: !(a<b)
  - 6: !(a<=b)
  - 8: a==b
  - 9: a<b
  - 10: a<=b
  - 11: false
  - 12: a!=b
  - 13: a>=b
  - 14: a>b
  - 15: true
- R6: For code c in 16 to 31, the result is that of code c-16, and the signaling attribute is inverted.
- R7: When `legacy_mode` is 1, predicate bits 4:3 are ignored and the code used is bits 2:0.
- R8: +0 and -0 compare equal to each other and to themselves.
- R9: Ordering follows the sign and then the magnitude. A negative value is below a positive one, and among two negatives the larger magnitude is the smaller value. Infinities are the extremes.
- R10: When an operand is a NaN, the predicate answers are:
  - true for codes 4, 5, 6, 8, 9, 10 and 15;
  - false for codes 0, 1, 2, 11, 12, 13 and 14.
  The code pairs c and c^4 within 0 to 15 always give complementary answers.
- R11: A signaling NaN in either operand sets `invalid_o` for every predicate.
- R12: A quiet NaN sets `invalid_o` only under a signaling predicate. The signaling predicates among codes 0 to 15 are those with bits 1:0 equal to 01 or 10. Predicate bit 4 inverts this.
- R13: `denorm_o` is 1 when either operand has exponent 0 and a nonzero fraction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_en | input | 1 | Capture enable for the output register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| pred | input | 5 | Predicate code |
| legacy_mode | input | 1 | Decode only predicate bits 2:0 |
| result_o | output | 1 | Registered compare answer |
| invalid_o | output | 1 | Registered invalid-operation flag |
| denorm_o | output | 1 | Registered denormal-input flag |

## Verification
The hardest case to reach from the ports is a quiet NaN under a predicate whose signaling attribute comes from bit 4. This combination has to appear together with legacy mode on and off. Uniformly random 32-bit operands almost never produce NaNs, signed zeros or denormals. The stimulus therefore draws most operands from a pool of special encodings, fills the rest with random bits, and sweeps all 32 codes over fixed pairs that include a quiet NaN, a signaling NaN and a zero pair of opposite signs.

// File: rtl/spc_pkg.sv
package spc_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int FP_W   = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = EXP_W + FRAC_W;
  localparam int PRED_W = 5;
  localparam int LEG_W  = 3;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             is_zero;
    logic             is_nan;
    logic             is_qnan;
    logic             is_snan;
    logic             is_denorm;
  } fp_class_t;

  typedef struct packed {
    logic [1:0] rel_sel;
    logic       hi_grp;
    logic       negate;
    logic       signaling;
  } pred_ctl_t;
endpackage

// File: rtl/spc_classify.sv
module spc_classify
  import spc_pkg::*;
(
  input  logic [FP_W-1:0] val,
  output fp_class_t       cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              exp_zero;
  logic              frac_nz;

  always_comb begin
    exp_f    = val[FP_W-2 -: EXP_W];
    frac_f   = val[FRAC_W-1:0];
    exp_ones = &exp_f;
    exp_zero = ~|exp_f;
    frac_nz  = |frac_f;

    cls.sign      = val[FP_W-1];
    cls.mag       = val[MAG_W-1:0];
    cls.is_zero   = exp_zero & ~frac_nz;
    cls.is_nan    = exp_ones & frac_nz;
    cls.is_qnan   = exp_ones & frac_f[FRAC_W-1];
    cls.is_snan   = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    cls.is_denorm = exp_zero & frac_nz;
  end
endmodule

// File: rtl/spc_order.sv
module spc_order
  import spc_pkg::*;
(
  input  fp_class_t a,
  input  fp_class_t b,
  output logic      lt,
  output logic      eq,
  output logic      unord
);
  logic both_zero;
  logic mag_eq;
  logic a_mag_lt;
  logic b_mag_lt;
  logic raw_lt;
  logic raw_eq;

  always_comb begin
    unord     = a.is_nan | b.is_nan;
    both_zero = a.is_zero & b.is_zero;
    mag_eq    = (a.mag == b.mag);
    a_mag_lt  = (a.mag < b.mag);
    b_mag_lt  = (b.mag < a.mag);

    raw_eq = both_zero | ((a.sign == b.sign) & mag_eq);

    if (both_zero)
      raw_lt = 1'b0;
    else if (a.sign != b.sign)
      raw_lt = a.sign;
    else if (a.sign)
      raw_lt = b_mag_lt;
    else
      raw_lt = a_mag_lt;

    lt = raw_lt & ~unord;
    eq = raw_eq & ~unord;
  end
endmodule

// File: rtl/spc_pred_decode.sv
module spc_pred_decode
  import spc_pkg::*;
(
  input  logic [PRED_W-1:0] pred,
  input  logic              legacy_mode,
  output pred_ctl_t         ctl
);
  logic [PRED_W-1:0] eff;

  always_comb begin
    eff = pred;
    if (legacy_mode)
      eff = {{(PRED_W-LEG_W){1'b0}}, pred[LEG_W-1:0]};

    ctl.rel_sel   = eff[1:0];
    ctl.negate    = eff[2];
    ctl.hi_grp    = eff[3];
    ctl.signaling = eff[0] ^ eff[1] ^ eff[4];
  end
endmodule

// File: rtl/spc_eval.sv
module spc_eval
  import spc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_en,
  input  logic [FP_W-1:0]   op_a,
  input  logic [FP_W-1:0]   op_b,
  input  logic [PRED_W-1:0] pred,
  input  logic              legacy_mode,
  output logic              result_o,
  output logic              invalid_o,
  output logic              denorm_o
);
  localparam int N_OPS = 2;

  logic [FP_W-1:0] ops [N_OPS];
  fp_class_t       cls [N_OPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar g = 0; g < N_OPS; g++) begin : g_cls
    spc_classify u_cls (
      .val (ops[g]),
      .cls (cls[g])
    );
  end

  logic lt_w, eq_w, un_w;

  spc_order u_order (
    .a     (cls[0]),
    .b     (cls[1]),
    .lt    (lt_w),
    .eq    (eq_w),
    .unord (un_w)
  );

  pred_ctl_t ctl;

  spc_pred_decode u_dec (
    .pred        (pred),
    .legacy_mode (legacy_mode),
    .ctl         (ctl)
  );

  logic base_rel;
  logic res_c, inv_c, den_c;

  always_comb begin
    if (ctl.hi_grp) begin
      unique case (ctl.rel_sel)
        2'd0:    base_rel = eq_w | un_w;
        2'd1:    base_rel = lt_w | un_w;
        2'd2:    base_rel = lt_w | eq_w | un_w;
        default: base_rel = 1'b0;
      endcase
    end else begin
      unique case (ctl.rel_sel)
        2'd0:    base_rel = eq_w;
        2'd1:    base_rel = lt_w;
        2'd2:    base_rel = lt_w | eq_w;
        default: base_rel = un_w;
      endcase
    end
    res_c = base_rel ^ ctl.negate;
    inv_c = cls[0].is_snan | cls[1].is_snan |
            (ctl.signaling & (cls[0].is_qnan | cls[1].is_qnan));
    den_c = cls[0].is_denorm | cls[1].is_denorm;
  end

  logic [2:0] out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (eval_en)
      out_d = {res_c, inv_c, den_c};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      out_q <= '0;
    else
      out_q <= out_d;
  end

  assign result_o  = out_q[2];
  assign invalid_o = out_q[1];
  assign denorm_o  = out_q[0];
endmodule

// File: rtl/spc_eval_chk.sv
module spc_eval_chk
  import spc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              eval_en,
  input logic [FP_W-1:0]   op_a,
  input logic [FP_W-1:0]   op_b,
  input logic [PRED_W-1:0] pred,
  input logic              legacy_mode,
  input logic              result_o,
  input logic              invalid_o,
  input logic              denorm_o
);
  logic a_snan, b_snan, a_nan, b_nan, a_den, b_den, zeros;
  logic [PRED_W-1:0] code;

  always_comb begin
    a_nan  = (&op_a[30:23]) && (op_a[22:0] != '0);
    b_nan  = (&op_b[30:23]) && (op_b[22:0] != '0);
    a_snan = a_nan && !op_a[22];
    b_snan = b_nan && !op_b[22];
    a_den  = (op_a[30:23] == '0) && (op_a[22:0] != '0);
    b_den  = (op_b[30:23] == '0) && (op_b[22:0] != '0);
    zeros  = (op_a[30:0] == '0) && (op_b[30:0] == '0);
    code   = legacy_mode ? {2'b00, pred[2:0]} : pred;
  end

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_en |=> $stable({result_o, invalid_o, denorm_o}));

  a_r11_snan_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && (a_snan || b_snan) |=> invalid_o);

  a_r13_denorm: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && (a_den || b_den) |=> denorm_o);

  a_r4_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && code[3:0] == 4'd3 |=> result_o == $past(a_nan || b_nan));

  a_r8_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && zeros && code[3:0] == 4'd0 |=> result_o);

  a_r5_false_true: assert property (@(posedge clk) disable iff (!rst_n)
    eval_en && code[3:0] == 4'd11 |=> !result_o);
endmodule

bind spc_eval spc_eval_chk i_spc_eval_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .eval_en     (eval_en),
  .op_a        (op_a),
  .op_b        (op_b),
  .pred        (pred),
  .legacy_mode (legacy_mode),
  .result_o    (result_o),
  .invalid_o   (invalid_o),
  .denorm_o    (denorm_o)
);

// File: tb/test_spc_eval.sv
`timescale 1ns/1ps
module test_spc_eval;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        eval_en;
  logic [31:0] op_a, op_b;
  logic [4:0]  pred;
  logic        legacy_mode;
  logic        result_o, invalid_o, denorm_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  spc_eval i_spc_eval (
    .clk(clk), .rst_n(rst_n), .eval_en(eval_en), .op_a(op_a), .op_b(op_b),
    .pred(pred), .legacy_mode(legacy_mode),
    .result_o(result_o), .invalid_o(invalid_o), .denorm_o(denorm_o)
  );

  function automatic logic signed [32:0] key(input logic [31:0] v);
    logic signed [32:0] m;
    m = {2'b00, v[30:0]};
    return v[31] ? -m : m;
  endfunction

  function automatic logic [2:0] model(input logic [31:0] a, input logic [31:0] b,
                                       input logic [4:0] p, input logic leg);
    logic na, nb, qa, qb, sa, sb, un, lt, eq, gt, r, sig;
    logic [4:0] c;
    logic [15:0] sigtab;
    na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    qa = na && a[22];  sa = na && !a[22];
    qb = nb && b[22];  sb = nb && !b[22];
    un = na || nb;
    lt = !un && (key(a) < key(b));
    eq = !un && (key(a) == key(b));
    gt = !un && (key(a) > key(b));
    c  = leg ? {2'b00, p[2:0]} : p;
    case (c[3:0])
      4'd0:  r = eq;
      4'd1:  r = lt;
      4'd2:  r = lt || eq;
      4'd3:  r = un;
      4'd4:  r = !eq;
      4'd5:  r = !lt;
      4'd6:  r = !(lt || eq);
      4'd7:  r = !un;
      4'd8:  r = eq || un;
      4'd9:  r = !(gt || eq);
      4'd10: r = !gt;
      4'd11: r = 1'b0;
      4'd12: r = !eq && !un;
      4'd13: r = gt || eq;
      4'd14: r = gt;
      default: r = 1'b1;
    endcase
    sigtab = 16'b0110_0110_0110_0110;
    sig = sigtab[c[3:0]] ^ c[4];
    return {r, sa || sb || (sig && (qa || qb)),
            ((a[30:23] == 0) && (a[22:0] != 0)) || ((b[30:23] == 0) && (b[22:0] != 0))};
  endfunction

  task automatic check(input string tag, input logic [2:0] exp_v);
    total++;
    if ({result_o, invalid_o, denorm_o} !== exp_v) begin
      bad++;
      $display("FAIL %s: a=%h b=%h pred=%0d leg=%0b got=%b exp=%b",
               tag, op_a, op_b, pred, legacy_mode,
               {result_o, invalid_o, denorm_o}, exp_v);
    end
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b,
                     input logic [4:0] p, input logic leg, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; pred = p; legacy_mode = leg; eval_en = 1'b1;
    @(negedge clk);
    check(tag, model(a, b, p, leg));
  endtask

  function automatic logic [31:0] special(input int idx);
    case (idx)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;
      2: return 32'h3F80_0000;  3: return 32'hBF80_0000;
      4: return 32'h4000_0000;  5: return 32'hC000_0000;
      6: return 32'h7F80_0000;  7: return 32'hFF80_0000;
      8: return 32'h7FC0_0000;  9: return 32'h7F80_0001;
      10: return 32'h0000_0001; 11: return 32'h8040_0000;
      12: return 32'h7F7F_FFFF; default: return 32'h0080_0000;
    endcase
  endfunction

  function automatic logic [31:0] pick();
    if ($urandom % 4 == 0) return $urandom;
    return special(int'($urandom % 14));
  endfunction

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog: run hung, got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; eval_en = 1'b0; op_a = '0; op_b = '0; pred = '0; legacy_mode = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 3'b000);
    rst_n = 1'b1;

    // R3 / R4: NaN kinds and infinity
    run(32'h7FC0_0000, 32'h3F80_0000, 5'd3, 1'b0, "R3 R4 qnan unordered");
    run(32'h7F80_0000, 32'h3F80_0000, 5'd3, 1'b0, "R3 inf is ordered");
    run(32'h7F80_0000, 32'h3F80_0000, 5'd7, 1'b0, "R4 ordered");
    run(32'h3F80_0000, 32'hFF80_0001, 5'd7, 1'b0, "R4 snan not ordered");
    // R5 / R9 ordering
    run(32'hC000_0000, 32'hBF80_0000, 5'd1, 1'b0, "R9 neg reversed lt");
    run(32'hBF80_0000, 32'h0000_0000, 5'd14, 1'b0, "R9 neg below zero");
    run(32'hFF80_0000, 32'h7F7F_FFFF, 5'd2, 1'b0, "R9 -inf smallest");
    run(32'h4000_0000, 32'h3F80_0000, 5'd13, 1'b0, "R5 ge");
    // R8 signed zero
    run(32'h8000_0000, 32'h0000_0000, 5'd0, 1'b0, "R8 -0 eq +0");
    run(32'h8000_0000, 32'h0000_0000, 5'd1, 1'b0, "R8 -0 not lt +0");
    // R10 complement on NaN
    run(32'h7FC0_0000, 32'h0000_0000, 5'd4, 1'b0, "R10 neq true on nan");
    run(32'h7FC0_0000, 32'h0000_0000, 5'd12, 1'b0, "R10 neq_oq false on nan");
    // R11 / R12 invalid
    run(32'h7F80_0001, 32'h0000_0000, 5'd0, 1'b0, "R11 snan quiet pred");
    run(32'h7FC0_0000, 32'h0000_0000, 5'd1, 1'b0, "R12 qnan signaling pred");
    run(32'h7FC0_0000, 32'h0000_0000, 5'd17, 1'b0, "R12 qnan bit4 quiet");
    run(32'h7FC0_0000, 32'h0000_0000, 5'd16, 1'b0, "R6 R12 qnan bit4 signaling");
    // R7 legacy
    run(32'h7FC0_0000, 32'h0000_0000, 5'd17, 1'b1, "R7 legacy drops bit4");
    run(32'h3F80_0000, 32'h4000_0000, 5'd11, 1'b1, "R7 legacy 11 is 3");
    // R13 denormal
    run(32'h0000_0001, 32'h0000_0000, 5'd0, 1'b0, "R13 denorm a");
    run(32'h3F80_0000, 32'h8040_0000, 5'd6, 1'b0, "R13 denorm b");

    // R6 sweep all codes over special pairs, both modes
    for (int p = 0; p < 32; p++) begin
      run(32'h7FC0_0000, 32'h3F80_0000, 5'(p), 1'b0, "R6 R10 sweep qnan");
      run(32'h7F80_0001, 32'h3F80_0000, 5'(p), 1'b0, "R6 R11 sweep snan");
      run(32'h8000_0000, 32'h0000_0000, 5'(p), 1'b0, "R6 R8 sweep zeros");
      run(32'hBF80_0000, 32'h3F80_0000, 5'(p), 1'b1, "R7 sweep legacy");
    end

    // R2 hold
    run(32'h3F80_0000, 32'h4000_0000, 5'd1, 1'b0, "R2 setup");
    held = model(32'h3F80_0000, 32'h4000_0000, 5'd1, 1'b0);
    @(negedge clk);
    eval_en = 1'b0; op_a = 32'h7F80_0001; op_b = 32'h0000_0001; pred = 5'd11;
    repeat (3) @(negedge clk);
    check("R2 hold when disabled", held);

    // random mix
    for (int i = 0; i < 3000; i++)
      run(pick(), pick(), 5'($urandom), 1'($urandom % 4 == 0), "R5 R9 R12 random");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule